// File: doc/BRIEF.md
# Key-Protected Configuration Register Guard

This block holds a small bank of configuration registers that drive chip-level controls, such as pad drivers, clock selects and peripheral enables. It sits behind a plain single-port bus: an address, a write strobe, write data, and a registered read-data return. The register contents are driven straight out of the block as one flat vector.

Each register is guarded by one of three policies. Two of them are protection policies and the third is open access.

- **Own lock word.** The register has a dedicated lock word. Writing that lock word's key opens it for a short, parameterised window. Within that window the lock admits exactly one write to its register, then closes again.
- **Kick pair.** The register has no lock of its own, but a global pair of kick words exists. In that case both kick words must hold their respective keys. While they do, the register accepts any number of writes, until software changes either kick word.
- **Unrestricted.** When a register has no lock of its own and the kick pair is not configured, writes to it are not restricted.

A write that the guard refuses leaves the target untouched and raises a sticky violation flag. Software clears that flag by writing one to it.

Top module: `key_guard`

## Requirements
- R1: After reset, every configuration register reads zero, the violation flag is clear, and every lock word and both kick words report closed.
- R2: Writing a lock word's key (defaults 0x0A5A0001 for lock 0 and 0x0A5A0002 for lock 1) opens that lock. A write to the matching register issued on any of the WINDOW clock edges after the key write (default 4) is then accepted.
- R3: A write to a lock-guarded register issued WINDOW+1 or more edges after the key write is rejected, because the lock has closed by itself.
- R4: Writing zero to an open lock word closes it at once, and the next write to its register is rejected.
- R5: Writing any value other than the key to a lock word leaves that lock closed.
- R6: One accepted write consumes the unlock. A second write to the same register, even inside the window, is rejected.
- R7: Registers without a lock word accept writes only while kick word 0 holds 0x83E70B13 and kick word 1 holds 0x95A4F1E0. The pair then stays open for any number of writes until either kick word is rewritten with another value.
- R8: A register with its own lock word ignores the kick pair. An open lock admits writes only to its own register.
- R9: With KICK_EN = 0, registers without a lock word accept every write.
- R10: A rejected write leaves the target unchanged and sets the violation flag. The flag stays set until a write to the status word with bit 0 = 1. Writing 0 to that bit has no effect.
- R11: Reads return data one cycle after the address is presented. The default address map is:
  - data registers at 0x00 to 0x03, always readable;
  - lock words at 0x10 and 0x11, kick words at 0x18 and 0x19, each reading 1 while its scheme is open and 0 while closed;
  - status word at 0x1F, reading the violation flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| violation | output | 1 | Sticky flag set by a rejected protected write |
| cfg_out | output | NUM_REGS*DATA_W | Configuration register contents, register i in slice i |

## Verification
The hardest condition to reach from the ports is the exact edge of the self-relocking window. Telling "last accepted cycle" apart from "first rejected cycle" needs a key write followed by a protected write with a precisely controlled gap. The stimulus therefore sweeps that gap from one cycle up to two cycles beyond WINDOW for every lock word, with inputs driven on the falling edge so that each gap is exact. Back-to-back writes exercise the one-shot consumption of an unlock, and a sweep over all four right/wrong combinations of the two kick words covers the dual-key condition.

// File: rtl/key_guard_pkg.sv
package key_guard_pkg;

  // Protection policy assigned to each configuration register
  typedef enum logic [1:0] {
    GUARD_FREE = 2'd0,
    GUARD_LOCK = 2'd1,
    GUARD_KICK = 2'd2
  } guard_e;

  // Registers below nlocks own a lock word; the rest fall to the kick pair
  // when it exists, otherwise they are unrestricted.
  function automatic guard_e guard_of(input int idx, input int nlocks, input bit kick_en);
    if (idx < nlocks) return GUARD_LOCK;
    if (kick_en) return GUARD_KICK;
    return GUARD_FREE;
  endfunction

  function automatic int count_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/key_guard_lock.sv
// One self-closing lock word: a correct key loads a down-counter; the lock
// is open while the counter is non-zero.
module key_guard_lock
  import key_guard_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY  = '1,
  parameter int              WINDOW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              consume,
  output logic              is_open
);

  localparam int CW = count_width(WINDOW);
  localparam logic [CW-1:0] LOAD = CW'(WINDOW);

  logic [CW-1:0] remain;
  logic          key_ok;

  assign key_ok = (key_data == KEY) && (KEY != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (key_wr) begin
      // zero or any wrong value closes the lock
      remain <= key_ok ? LOAD : '0;
    end else if (consume) begin
      remain <= '0;
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
    end
  end

  assign is_open = (remain != '0);

endmodule

// File: rtl/key_guard_kick.sv
// Global two-word kick unlock; open while both words hold their keys.
module key_guard_kick #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY0   = '1,
  parameter logic [DATA_W-1:0] KEY1   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr0,
  input  logic              wr1,
  input  logic [DATA_W-1:0] wdata,
  output logic              is_open
);

  logic [DATA_W-1:0] word0;
  logic [DATA_W-1:0] word1;

  always_ff @(posedge clk) begin
    if (rst) begin
      word0 <= '0;
      word1 <= '0;
    end else begin
      if (wr0) word0 <= wdata;
      if (wr1) word1 <= wdata;
    end
  end

  assign is_open = (word0 == KEY0) && (word1 == KEY1);

endmodule

// File: rtl/key_guard_bank.sv
// Flat bank of configuration registers with per-register write enables.
module key_guard_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_REGS-1:0]          we,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NUM_REGS*DATA_W-1:0]   q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i*DATA_W +: DATA_W] <= '0;
      end else if (we[i]) begin
        q[i*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

endmodule

// File: rtl/key_guard.sv
module key_guard
  import key_guard_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 4,
  parameter int NUM_LOCKS  = 2,
  parameter int WINDOW     = 4,
  parameter bit KICK_EN    = 1'b1,
  parameter int REG_BASE   = 'h00,
  parameter int LOCK_BASE  = 'h10,
  parameter int KICK0_ADDR = 'h18,
  parameter int KICK1_ADDR = 'h19,
  parameter int STAT_ADDR  = 'h1F,
  parameter logic [NUM_LOCKS*DATA_W-1:0] LOCK_KEYS = {32'h0A5A_0002, 32'h0A5A_0001},
  parameter logic [DATA_W-1:0] KICK_KEY0 = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KICK_KEY1 = 32'h95A4_F1E0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       violation,
  output logic [NUM_REGS*DATA_W-1:0] cfg_out
);

  localparam logic [ADDR_W-1:0] A_KICK0 = ADDR_W'(KICK0_ADDR);
  localparam logic [ADDR_W-1:0] A_KICK1 = ADDR_W'(KICK1_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_ADDR);

  logic [NUM_REGS-1:0]  reg_hit;
  logic [NUM_REGS-1:0]  reg_allowed;
  logic [NUM_REGS-1:0]  reg_we;
  logic [NUM_LOCKS-1:0] lock_wr;
  logic [NUM_LOCKS-1:0] lock_open;
  logic                 kick_open;
  logic                 reject;
  logic                 stat_wr;
  logic [DATA_W-1:0]    rd_next;

  // ---------------- write decode ----------------
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam guard_e GK = guard_of(i, NUM_LOCKS, KICK_EN);
    assign reg_hit[i] = bus_wr && (bus_addr == ADDR_W'(REG_BASE + i));
    if (GK == GUARD_LOCK) begin : g_lk
      assign reg_allowed[i] = lock_open[i];
    end else if (GK == GUARD_KICK) begin : g_kk
      assign reg_allowed[i] = kick_open;
    end else begin : g_fr
      assign reg_allowed[i] = 1'b1;
    end
  end

  assign reg_we  = reg_hit & reg_allowed;
  assign reject  = |(reg_hit & ~reg_allowed);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);

  // ---------------- per-register lock words ----------------
  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    assign lock_wr[g] = bus_wr && (bus_addr == ADDR_W'(LOCK_BASE + g));
    key_guard_lock #(
      .DATA_W (DATA_W),
      .KEY    (LOCK_KEYS[g*DATA_W +: DATA_W]),
      .WINDOW (WINDOW)
    ) u_lock (
      .clk      (clk),
      .rst      (rst),
      .key_wr   (lock_wr[g]),
      .key_data (bus_wdata),
      .consume  (reg_we[g]),
      .is_open  (lock_open[g])
    );
  end

  // ---------------- global kick pair ----------------
  if (KICK_EN) begin : g_kick
    key_guard_kick #(
      .DATA_W (DATA_W),
      .KEY0   (KICK_KEY0),
      .KEY1   (KICK_KEY1)
    ) u_kick (
      .clk     (clk),
      .rst     (rst),
      .wr0     (bus_wr && (bus_addr == A_KICK0)),
      .wr1     (bus_wr && (bus_addr == A_KICK1)),
      .wdata   (bus_wdata),
      .is_open (kick_open)
    );
  end else begin : g_nokick
    assign kick_open = 1'b0;
  end

  // ---------------- register bank ----------------
  key_guard_bank #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wdata (bus_wdata),
    .q     (cfg_out)
  );

  // ---------------- sticky violation ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      violation <= 1'b0;
    end else if (reject) begin
      violation <= 1'b1;
    end else if (stat_wr && bus_wdata[0]) begin
      violation <= 1'b0;
    end
  end

  // ---------------- registered read path ----------------
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (bus_addr == ADDR_W'(REG_BASE + i)) rd_next = cfg_out[i*DATA_W +: DATA_W];
    end
    for (int g = 0; g < NUM_LOCKS; g++) begin
      if (bus_addr == ADDR_W'(LOCK_BASE + g)) rd_next = DATA_W'(lock_open[g]);
    end
    if (bus_addr == A_KICK0 || bus_addr == A_KICK1) rd_next = DATA_W'(kick_open);
    if (bus_addr == A_STAT) rd_next = DATA_W'(violation);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

endmodule

// File: rtl/key_guard_chk.sv
module key_guard_chk #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 4,
  parameter int NUM_LOCKS = 2,
  parameter int WINDOW    = 4,
  parameter bit KICK_EN   = 1'b1,
  parameter int REG_BASE  = 'h00,
  parameter int LOCK_BASE = 'h10,
  parameter int STAT_ADDR = 'h1F,
  parameter logic [NUM_LOCKS*DATA_W-1:0] LOCK_KEYS = '1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_wr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       violation,
  input logic [NUM_REGS*DATA_W-1:0] cfg_out,
  input logic [NUM_LOCKS-1:0]       lock_open,
  input logic                       kick_open
);

  // R10: the flag only falls on a write of 1 to the status word
  p_viol_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    violation && !(bus_wr && bus_addr == ADDR_W'(STAT_ADDR) && bus_wdata[0]) |=> violation);

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lk
    int age;
    always_ff @(posedge clk) begin
      if (rst) age <= WINDOW + 1;
      else if (bus_wr && bus_addr == ADDR_W'(LOCK_BASE + g)
               && bus_wdata == LOCK_KEYS[g*DATA_W +: DATA_W]) age <= 1;
      else if (age <= WINDOW) age <= age + 1;
    end

    // R3: a lock is never open beyond WINDOW edges after its key
    p_window_r3: assert property (@(posedge clk) disable iff (rst)
      lock_open[g] |-> age <= WINDOW);

    // R4: zero written to a lock word closes it
    p_zero_relock_r4: assert property (@(posedge clk) disable iff (rst)
      bus_wr && bus_addr == ADDR_W'(LOCK_BASE + g) && bus_wdata == '0 |=> !lock_open[g]);

    // R6: an accepted write consumes the unlock
    p_one_shot_r6: assert property (@(posedge clk) disable iff (rst)
      bus_wr && bus_addr == ADDR_W'(REG_BASE + g) && lock_open[g] |=> !lock_open[g]);

    // R10: a closed lock drops the write and flags it
    p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst)
      bus_wr && bus_addr == ADDR_W'(REG_BASE + g) && !lock_open[g]
      |=> $stable(cfg_out[g*DATA_W +: DATA_W]) && violation);
  end

  if (KICK_EN) begin : g_kk
    for (genvar i = NUM_LOCKS; i < NUM_REGS; i++) begin : g_r
      // R7: kick-guarded registers change only while the pair is open
      p_kick_hold_r7: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == ADDR_W'(REG_BASE + i) && !kick_open
        |=> $stable(cfg_out[i*DATA_W +: DATA_W]) && violation);
    end
  end

endmodule

bind key_guard key_guard_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_REGS  (NUM_REGS),
  .NUM_LOCKS (NUM_LOCKS),
  .WINDOW    (WINDOW),
  .KICK_EN   (KICK_EN),
  .REG_BASE  (REG_BASE),
  .LOCK_BASE (LOCK_BASE),
  .STAT_ADDR (STAT_ADDR),
  .LOCK_KEYS (LOCK_KEYS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .violation (violation),
  .cfg_out   (cfg_out),
  .lock_open (lock_open),
  .kick_open (kick_open)
);

// File: tb/key_guard_bench.sv
module key_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WINDOW     = 4;
  localparam int WATCHDOG   = 20000;
  localparam logic [5:0] A_LOCK = 6'h10;
  localparam logic [5:0] A_K0   = 6'h18;
  localparam logic [5:0] A_K1   = 6'h19;
  localparam logic [5:0] A_STAT = 6'h1F;
  localparam logic [31:0] LKEY0 = 32'h0A5A_0001;
  localparam logic [31:0] LKEY1 = 32'h0A5A_0002;
  localparam logic [31:0] KKEY0 = 32'h83E7_0B13;
  localparam logic [31:0] KKEY1 = 32'h95A4_F1E0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [5:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  rdata, rdata_b;
  logic         viol, viol_b;
  logic [127:0] cfg, cfg_b;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [31:0] em [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  key_guard u_key_guard (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .violation(viol), .cfg_out(cfg)
  );

  key_guard #(.KICK_EN(1'b0)) u_key_guard_open (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .violation(viol_b), .cfg_out(cfg_b)
  );

  function automatic logic [31:0] slot(input logic [127:0] v, input int i);
    return v[i*32 +: 32];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change on the falling edge; one write per rising edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_viol();
    wr(A_STAT, 32'h1);
    chk("R10 clear", {31'b0, viol}, 32'h0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 4; i++) em[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 4; i++) chk("R1 cfg", slot(cfg, i), 32'h0);
    chk("R1 viol", {31'b0, viol}, 32'h0);
    rd(A_LOCK, r);     chk("R1 lock0 closed", r, 32'h0);
    rd(A_LOCK + 1, r); chk("R1 lock1 closed", r, 32'h0);
    rd(A_K0, r);       chk("R1 kick closed", r, 32'h0);

    // R2 / R3 window sweep over both locks
    for (int lk = 0; lk < 2; lk++) begin
      for (int k = 1; k <= WINDOW + 2; k++) begin
        logic [31:0] v;
        v = 32'h1000_0000 + lk * 256 + k;
        wr(A_LOCK + 6'(lk), lk == 0 ? LKEY0 : LKEY1);
        idle(k - 1);
        wr(6'(lk), v);
        if (k <= WINDOW) begin
          em[lk] = v;
          chk("R2 write in window", slot(cfg, lk), em[lk]);
          chk("R2 no violation", {31'b0, viol}, 32'h0);
        end else begin
          chk("R3 write after relock", slot(cfg, lk), em[lk]);
          chk("R3 violation", {31'b0, viol}, 32'h1);
          clear_viol();
        end
      end
    end

    // R6 one write per unlock
    wr(A_LOCK, LKEY0);
    wr(6'd0, 32'hAAAA_0001); em[0] = 32'hAAAA_0001;
    wr(6'd0, 32'hAAAA_0002);
    chk("R6 second write dropped", slot(cfg, 0), em[0]);
    chk("R6 violation", {31'b0, viol}, 32'h1);
    clear_viol();

    // R11 reads, R4 zero relock
    rd(6'd0, r); chk("R11 data read", r, em[0]);
    wr(A_LOCK, LKEY0);
    rd(A_LOCK, r); chk("R11 lock reads open", r, 32'h1);
    wr(A_LOCK, 32'h0);
    rd(A_LOCK, r); chk("R4 lock reads closed", r, 32'h0);
    wr(6'd0, 32'hBBBB_0000);
    chk("R4 write rejected", slot(cfg, 0), em[0]);
    clear_viol();

    // R5 wrong keys
    for (int w = 0; w < 4; w++) begin
      logic [31:0] bad;
      case (w)
        0: bad = LKEY0 ^ 32'h1;
        1: bad = LKEY0 + 32'h100;
        2: bad = LKEY1;
        default: bad = 32'hFFFF_FFFF;
      endcase
      wr(A_LOCK, bad);
      rd(A_LOCK, r); chk("R5 lock stays closed", r, 32'h0);
      wr(6'd0, 32'hCCCC_0000 + w);
      chk("R5 write rejected", slot(cfg, 0), em[0]);
      chk("R5 violation", {31'b0, viol}, 32'h1);
      clear_viol();
    end

    // R7 kick pair: all four right/wrong combinations
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        logic open;
        logic [31:0] v;
        open = (a == 1) && (b == 1);
        v = 32'h2000_0000 + a * 16 + b;
        wr(A_K0, a == 1 ? KKEY0 : KKEY0 ^ 32'h5);
        wr(A_K1, b == 1 ? KKEY1 : 32'h33);
        rd(A_K0, r); chk("R11 kick status", r, {31'b0, open});
        wr(6'd2, v);
        if (open) em[2] = v;
        chk("R7 kick gated write", slot(cfg, 2), em[2]);
        if (!open) clear_viol();
      end
    end
    idle(10);
    wr(6'd3, 32'h3000_0001); em[3] = 32'h3000_0001;
    wr(6'd3, 32'h3000_0002); em[3] = 32'h3000_0002;
    chk("R7 stays open", slot(cfg, 3), em[3]);
    chk("R7 no violation", {31'b0, viol}, 32'h0);

    // R8 own-lock precedence
    wr(6'd0, 32'hDDDD_0000);
    chk("R8 kick ignored by locked reg", slot(cfg, 0), em[0]);
    clear_viol();
    wr(A_LOCK, LKEY0);
    wr(6'd1, 32'hDDDD_0001);
    chk("R8 lock0 does not open reg1", slot(cfg, 1), em[1]);
    clear_viol();
    wr(A_LOCK, 32'h0);

    // R7 clearing either kick word closes the pair
    wr(A_K0, 32'h0);
    wr(6'd3, 32'h3000_0003);
    chk("R7 closed by kick0", slot(cfg, 3), em[3]);
    clear_viol();
    wr(A_K0, KKEY0);
    wr(A_K1, 32'h0);
    wr(6'd3, 32'h3000_0004);
    chk("R7 closed by kick1", slot(cfg, 3), em[3]);

    // R10 sticky flag, W1C
    wr(A_STAT, 32'h0);
    chk("R10 write 0 keeps flag", {31'b0, viol}, 32'h1);
    rd(A_STAT, r); chk("R11 status read", r, 32'h1);
    wr(A_STAT, 32'h1);
    chk("R10 write 1 clears", {31'b0, viol}, 32'h0);

    // R9 no kick pair: non-locked registers are free
    wr(6'd2, 32'h5555_AAAA);
    chk("R9 free write", slot(cfg_b, 2), 32'h5555_AAAA);
    wr(6'd3, 32'h0F0F_0F0F);
    chk("R9 free write reg3", slot(cfg_b, 3), 32'h0F0F_0F0F);
    chk("R9 guarded copy unchanged", slot(cfg, 3), em[3]);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule